// File: doc/BRIEF.md
# Single-Bus Register-Transfer Processor Core

This block is a 32-bit processor core in which every transfer between its registers travels over one shared internal bus. It holds thirty-two general registers, a program counter, an instruction register, a memory address register, a memory data register, an operand latch `A` in front of the arithmetic unit and a result latch `C` after it. A 3-bit step counter feeds a decoder that produces eight one-hot time steps. A hardwired sequencer uses them to fetch each instruction and then execute it with one bus transfer per step. When the instruction's last step is done, the counter returns to the first step.

The core runs register-register arithmetic and logic, two unary operations, immediate forms, and a word load and store. Its memory port is a plain synchronous interface. The address always comes from the memory address register. Read data is expected in the same cycle the address is presented. A write takes effect at the clock edge that ends a cycle in which the write enable is high.

Top module: `unibus_core`

## Requirements
- R1: While `rst_n` is low, `step` equals 8'h01 (first step), `mem_addr` is 0 and `mem_we` is 0. The program counter restarts at 0, so the first fetch reads address 0.
- R2: `step` is always one-hot. It moves up one position per clock and returns to 8'h01 after the last step of each instruction. Sequence lengths are 6 cycles for three-register and immediate forms, 5 for unary forms, 8 for load and store, and 4 for an undefined opcode.
- R3: Fetch uses three steps. In step 0 the address register takes the program counter and `C` takes PC+4. In step 1 the fetched word is latched from `mem_rdata` while `mem_addr` shows the PC, and the PC takes `C`. In step 2 the instruction register takes the fetched word. Successive instructions are therefore fetched from addresses 0, 4, 8 and so on.
- R4: The instruction word is laid out as follows. The opcode is in bits [31:27]. The destination/data register `ra` is in [26:22]. The first source/base register `rb` is in [21:17]. The second source `rc` is in [16:12]. A 17-bit constant is in [16:0]. Opcodes: load 1, store 3, add 12, add-immediate 13, subtract 14, negate 15, and 20, and-immediate 21, or 22, or-immediate 23, invert 24. Every other value is undefined.
- R5: Add, subtract, and, and or write R[ra] = R[rb] op R[rc]. Subtract computes R[rb] - R[rc] modulo 2^32.
- R6: Invert writes R[ra] = ~R[rb]. Negate writes R[ra] = -R[rb] (two's complement).
- R7: The immediate forms write R[ra] = R[rb] op sext(IR[16:0]), where the constant is sign-extended from bit 16. Register 0 used as `rb` here supplies its stored value.
- R8: The effective address of a load or store is base + sext(IR[16:0]). The base is zero when the `rb` field is 0, whatever register 0 holds, and R[rb] otherwise.
- R9: A store drives `mem_we` high for exactly one cycle, during step 7 of its sequence. During that cycle `mem_addr` is the effective address and `mem_wdata` is R[ra].
- R10: A load writes the memory word at the effective address into R[ra].
- R11: An undefined opcode returns the sequencer to step 0 after step 3 and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Memory address, driven from the address register |
| mem_wdata | output | 32 | Store data, driven from the memory data register |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 32 | Memory read data, valid in the cycle the address is shown |
| step | output | 8 | One-hot current time step |

## Verification
Two cases are hardest to reach from the ports: the zero-base selection of R8 and the silence of an undefined opcode. Both need register contents that can only be seen through later stores. The stimulus first writes a nonzero value into register 0. It then stores with a zero base field, so the address reveals whether the register's contents leaked in. An add-immediate that reads register 0 shows the opposite rule. An undefined word aimed at an already-filled register is placed ahead of that register's store. Every store is also checked against the cycle in which it must occur, which proves the sequence length of every instruction before it.

// File: rtl/ubdp_pkg.sv
package ubdp_pkg;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NEG, ALU_NOT, ALU_INC4, ALU_PASS
   } alu_op_e;

   typedef enum logic [2:0] {
      CL_BIN, CL_IMM, CL_UNA, CL_LD, CL_ST, CL_BAD
   } op_class_e;

   typedef enum logic [2:0] {
      SRC_PC, SRC_C, SRC_MBR, SRC_REG, SRC_IMM, SRC_ZERO, SRC_MAR
   } bus_src_e;

   typedef struct packed {
      op_class_e cls;
      alu_op_e   alu;
   } dec_t;

   localparam int OPC_W = 5;
   localparam logic [OPC_W-1:0] OPC_LD   = 5'd1;
   localparam logic [OPC_W-1:0] OPC_ST   = 5'd3;
   localparam logic [OPC_W-1:0] OPC_ADD  = 5'd12;
   localparam logic [OPC_W-1:0] OPC_ADDI = 5'd13;
   localparam logic [OPC_W-1:0] OPC_SUB  = 5'd14;
   localparam logic [OPC_W-1:0] OPC_NEG  = 5'd15;
   localparam logic [OPC_W-1:0] OPC_AND  = 5'd20;
   localparam logic [OPC_W-1:0] OPC_ANDI = 5'd21;
   localparam logic [OPC_W-1:0] OPC_OR   = 5'd22;
   localparam logic [OPC_W-1:0] OPC_ORI  = 5'd23;
   localparam logic [OPC_W-1:0] OPC_NOT  = 5'd24;

   function automatic dec_t decode_op(logic [OPC_W-1:0] opc);
      dec_t d;
      case (opc)
         OPC_ADD:  d = '{cls: CL_BIN, alu: ALU_ADD};
         OPC_SUB:  d = '{cls: CL_BIN, alu: ALU_SUB};
         OPC_AND:  d = '{cls: CL_BIN, alu: ALU_AND};
         OPC_OR:   d = '{cls: CL_BIN, alu: ALU_OR};
         OPC_ADDI: d = '{cls: CL_IMM, alu: ALU_ADD};
         OPC_ANDI: d = '{cls: CL_IMM, alu: ALU_AND};
         OPC_ORI:  d = '{cls: CL_IMM, alu: ALU_OR};
         OPC_NEG:  d = '{cls: CL_UNA, alu: ALU_NEG};
         OPC_NOT:  d = '{cls: CL_UNA, alu: ALU_NOT};
         OPC_LD:   d = '{cls: CL_LD,  alu: ALU_ADD};
         OPC_ST:   d = '{cls: CL_ST,  alu: ALU_ADD};
         default:  d = '{cls: CL_BAD, alu: ALU_PASS};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/ubdp_step_gen.sv
module ubdp_step_gen #(
   parameter int STEP_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   output logic [(1<<STEP_W)-1:0] step
);
   localparam int STEPS = 1 << STEP_W;

   logic [STEP_W-1:0] cnt;

   initial begin : chk_params
      assert (STEP_W >= 3) else $error("step counter must give at least eight steps");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   for (genvar i = 0; i < STEPS; i++) begin : g_dec
      assign step[i] = (cnt == STEP_W'(i));
   end

   AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(step)); // R2
   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step[STEPS-1]) |=> (step == ($past(step) << 1))); // R2
   AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> step[0]); // R2

endmodule

// File: rtl/ubdp_alu.sv
module ubdp_alu
   import ubdp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (op)
         ALU_ADD:  y = a + b;
         ALU_SUB:  y = a - b;
         ALU_AND:  y = a & b;
         ALU_OR:   y = a | b;
         ALU_NEG:  y = '0 - b;
         ALU_NOT:  y = ~b;
         ALU_INC4: y = b + DATA_W'(4);
         default:  y = b;
      endcase
   end
endmodule

// File: rtl/ubdp_regfile.sv
module ubdp_regfile #(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [$clog2(REG_CNT)-1:0] waddr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [$clog2(REG_CNT)-1:0] raddr,
   output logic [DATA_W-1:0]          rdata
);
   logic [DATA_W-1:0] regs [REG_CNT];

   for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   q <= '0;
         else if (we && (waddr == $clog2(REG_CNT)'(i))) q <= wdata;
      end
      assign regs[i] = q;
   end

   assign rdata = regs[raddr];
endmodule

// File: rtl/unibus_core.sv
module unibus_core
   import ubdp_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 32,
   parameter int STEP_W  = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   output logic [DATA_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   output logic                   mem_we,
   input  logic [DATA_W-1:0]      mem_rdata,
   output logic [(1<<STEP_W)-1:0] step
);
   localparam int STEPS  = 1 << STEP_W;
   localparam int REG_AW = $clog2(REG_CNT);
   localparam int FLD_W  = 5;
   localparam int IMM_W  = 17;

   initial begin : chk_params
      assert (DATA_W >= 32) else $error("instruction fields need a 32-bit word");
      assert (REG_AW <= FLD_W && REG_CNT == (1 << REG_AW))
         else $error("register count must be a power of two up to 32");
   end

   logic [DATA_W-1:0] pc, ir, mar, mbr, a_q, c_q;
   logic [DATA_W-1:0] bus, alu_y, rf_rdata, imm_ext;
   logic [FLD_W-1:0]  f_ra, f_rb, f_rc, rsel;
   logic              mar_ld, pc_ld, ir_ld, a_ld, c_ld, rf_we, we_c, clr;
   logic              mbr_from_mem, mbr_from_bus;
   alu_op_e           alu_op;
   bus_src_e          src;
   dec_t              dec;

   assign f_ra    = ir[26:22];
   assign f_rb    = ir[21:17];
   assign f_rc    = ir[16:12];
   assign imm_ext = {{(DATA_W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
   assign dec     = decode_op(ir[31:27]);

   ubdp_step_gen #(.STEP_W(STEP_W)) u_steps (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step)
   );

   ubdp_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(f_ra[REG_AW-1:0]),
      .wdata(bus), .raddr(rsel[REG_AW-1:0]), .rdata(rf_rdata)
   );

   ubdp_alu #(.DATA_W(DATA_W)) u_alu (
      .op(alu_op), .a(a_q), .b(bus), .y(alu_y)
   );

   // Hardwired sequencer: one bus transfer per step
   always_comb begin
      src = SRC_PC;  rsel = f_rb;  alu_op = ALU_PASS;
      mar_ld = 1'b0; pc_ld = 1'b0; ir_ld = 1'b0; a_ld = 1'b0; c_ld = 1'b0;
      rf_we = 1'b0;  we_c = 1'b0;  clr = 1'b0;
      mbr_from_mem = 1'b0; mbr_from_bus = 1'b0;
      unique case (1'b1)
         step[0]: begin src = SRC_PC; mar_ld = 1'b1; c_ld = 1'b1; alu_op = ALU_INC4; end
         step[1]: begin src = SRC_C; pc_ld = 1'b1; mbr_from_mem = 1'b1; end
         step[2]: begin src = SRC_MBR; ir_ld = 1'b1; end
         step[3]: begin
            unique case (dec.cls)
               CL_BIN, CL_IMM: begin src = SRC_REG; a_ld = 1'b1; end
               CL_UNA: begin src = SRC_REG; c_ld = 1'b1; alu_op = dec.alu; end
               CL_LD, CL_ST: begin
                  src  = (f_rb == '0) ? SRC_ZERO : SRC_REG;
                  a_ld = 1'b1;
               end
               default: clr = 1'b1;
            endcase
         end
         step[4]: begin
            unique case (dec.cls)
               CL_BIN: begin src = SRC_REG; rsel = f_rc; c_ld = 1'b1; alu_op = dec.alu; end
               CL_IMM, CL_LD, CL_ST: begin src = SRC_IMM; c_ld = 1'b1; alu_op = dec.alu; end
               CL_UNA: begin src = SRC_C; rf_we = 1'b1; clr = 1'b1; end
               default: clr = 1'b1;
            endcase
         end
         step[5]: begin
            unique case (dec.cls)
               CL_BIN, CL_IMM: begin src = SRC_C; rf_we = 1'b1; clr = 1'b1; end
               CL_LD, CL_ST:   begin src = SRC_C; mar_ld = 1'b1; end
               default: clr = 1'b1;
            endcase
         end
         step[6]: begin
            unique case (dec.cls)
               CL_LD:   begin src = SRC_MAR; mbr_from_mem = 1'b1; end
               CL_ST:   begin src = SRC_REG; rsel = f_ra; mbr_from_bus = 1'b1; end
               default: clr = 1'b1;
            endcase
         end
         step[7]: begin
            unique case (dec.cls)
               CL_LD:   begin src = SRC_MBR; rf_we = 1'b1; clr = 1'b1; end
               CL_ST:   begin src = SRC_MBR; we_c = 1'b1; clr = 1'b1; end
               default: clr = 1'b1;
            endcase
         end
         default: clr = 1'b1;
      endcase
   end

   // The single internal bus
   always_comb begin
      unique case (src)
         SRC_PC:   bus = pc;
         SRC_C:    bus = c_q;
         SRC_MBR:  bus = mbr;
         SRC_REG:  bus = rf_rdata;
         SRC_IMM:  bus = imm_ext;
         SRC_MAR:  bus = mar;
         default:  bus = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= '0; ir <= '0; mar <= '0; mbr <= '0; a_q <= '0; c_q <= '0;
      end else begin
         if (pc_ld)             pc  <= bus;
         if (ir_ld)             ir  <= bus;
         if (mar_ld)            mar <= bus;
         if (a_ld)              a_q <= bus;
         if (c_ld)              c_q <= alu_y;
         if (mbr_from_mem)      mbr <= mem_rdata;
         else if (mbr_from_bus) mbr <= bus;
      end
   end

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign mem_we    = we_c;

   AST_WE_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> step[7]); // R9
   AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      step[1] |-> (mem_addr == pc)); // R3
   AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      step[1] |=> (pc == $past(pc) + DATA_W'(4))); // R3
   AST_ZERO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (step[3] && (dec.cls == CL_LD || dec.cls == CL_ST) && f_rb == '0) |=> (a_q == '0)); // R8
   AST_BAD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (step[3] && dec.cls == CL_BAD) |=> step[0]); // R11
   AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (step[3] && dec.cls == CL_BAD) |=> ($stable(pc) && $stable(mar) && $stable(c_q))); // R11
   AST_BUS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(bus)); // R2

endmodule

// File: tb/unibus_core_bench.sv
module unibus_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   // Opcode encoding (R4)
   localparam logic [4:0] OP_LD = 5'd1, OP_ST = 5'd3, OP_ADD = 5'd12, OP_ADDI = 5'd13;
   localparam logic [4:0] OP_SUB = 5'd14, OP_NEG = 5'd15, OP_AND = 5'd20, OP_ANDI = 5'd21;
   localparam logic [4:0] OP_OR = 5'd22, OP_ORI = 5'd23, OP_NOT = 5'd24, OP_BAD = 5'd31;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we;
   logic [7:0]  step;

   unibus_core u_unibus_core (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .step(step)
   );

   logic [31:0] mem [0:255];
   assign mem_rdata = mem[mem_addr[9:2]];
   always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      int          cyc;
      string       req;
   } item_t;

   item_t sb[$];
   int checks = 0, errors = 0, cyc = 0, onehot_bad = 0, slot = 0, sched = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc(logic [4:0] op, int ra, int rb, logic [16:0] low);
      return {op, 5'(ra), 5'(rb), low};
   endfunction

   function automatic logic [16:0] rc_f(int rc);
      return {5'(rc), 12'h000};
   endfunction

   // Driver: places an instruction and advances the expected start cycle
   task automatic put(logic [31:0] w, int len);
      mem[slot] = w;
      slot++;
      sched += len;
   endtask

   task automatic st(int ra, int rb, logic [16:0] disp, logic [31:0] ea, logic [31:0] dat, string req);
      item_t it;
      it.addr = ea; it.data = dat; it.cyc = sched + 7; it.req = req;
      sb.push_back(it);
      put(enc(OP_ST, ra, rb, disp), 8);
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (!$onehot(step)) onehot_bad++;
         if (cyc == 1) check(mem_addr == 32'h0, "R3", "first fetch address", mem_addr, 32'h0);
         if (cyc == 3) check(step == 8'h08, "R2", "step after three clocks", {24'h0, step}, 32'h08);
         if (cyc == 6) check(step == 8'h01, "R2", "return to first step", {24'h0, step}, 32'h01);
         if (cyc == 7) check(mem_addr == 32'h4, "R3", "second fetch address", mem_addr, 32'h4);
         if (mem_we) begin : pop
            item_t it;
            if (sb.size() == 0) begin
               check(1'b0, "R9", "unexpected write", mem_addr, 32'h0);
            end else begin
               it = sb.pop_front();
               check(mem_addr == it.addr, "R8", "store address", mem_addr, it.addr);
               check(mem_wdata == it.data, it.req, "store data", mem_wdata, it.data);
               check(cyc == it.cyc, "R9", "store cycle", 32'(cyc), 32'(it.cyc));
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      put(enc(OP_ADDI, 1, 0, 17'h00005), 6);        // r1 = 5
      put(enc(OP_ADDI, 2, 0, 17'h1FFFD), 6);        // r2 = -3, R7 sign extension
      put(enc(OP_ADD, 3, 1, rc_f(2)), 6);           // r3 = 2
      put(enc(OP_SUB, 4, 1, rc_f(2)), 6);           // r4 = 8
      put(enc(OP_AND, 5, 1, rc_f(2)), 6);           // r5 = 5
      put(enc(OP_OR, 6, 1, rc_f(2)), 6);            // r6 = FFFFFFFD
      put(enc(OP_NOT, 7, 2, 17'h0), 5);             // r7 = 2
      put(enc(OP_NEG, 8, 1, 17'h0), 5);             // r8 = FFFFFFFB
      put(enc(OP_ANDI, 9, 6, 17'h00F0F), 6);        // r9 = 0F0D
      put(enc(OP_ORI, 10, 1, 17'h10000), 6);        // r10 = FFFF0005
      put(enc(OP_ADDI, 0, 0, 17'h00040), 6);        // r0 = 40
      put(enc(OP_BAD, 3, 3, 17'h1FFFF), 4);         // R11: must not touch r3
      st(3, 0, 17'h00080, 32'h80, 32'h2, "R11");    // r3 kept, zero base (R8)
      st(4, 0, 17'h00084, 32'h84, 32'h8, "R5");
      st(5, 0, 17'h00088, 32'h88, 32'h5, "R5");
      st(6, 0, 17'h0008C, 32'h8C, 32'hFFFFFFFD, "R5");
      st(7, 0, 17'h00090, 32'h90, 32'h2, "R6");
      st(8, 0, 17'h00094, 32'h94, 32'hFFFFFFFB, "R6");
      st(9, 0, 17'h00098, 32'h98, 32'h00000F0D, "R7");
      st(10, 0, 17'h0009C, 32'h9C, 32'hFFFF0005, "R7");
      put(enc(OP_ADDI, 11, 0, 17'h00050), 6);       // R7: r11 = 40 + 50 = 90
      st(1, 11, 17'h00020, 32'hB0, 32'h5, "R8");    // nonzero base
      put(enc(OP_LD, 12, 0, 17'h00080), 8);         // R10: r12 = 2
      st(12, 0, 17'h000B4, 32'hB4, 32'h2, "R10");
      put(enc(OP_LD, 13, 11, 17'h1FFFC), 8);        // R10: r13 = mem[8C]
      st(13, 0, 17'h000B8, 32'hB8, 32'hFFFFFFFD, "R10");
      st(0, 0, 17'h000BC, 32'hBC, 32'h40, "R7");    // r0 holds its written value

      // R1: reset state
      repeat (3) @(negedge clk);
      check(step == 8'h01, "R1", "step in reset", {24'h0, step}, 32'h01);
      check(mem_addr == 32'h0, "R1", "address in reset", mem_addr, 32'h0);
      check(mem_we == 1'b0, "R1", "write enable in reset", {31'h0, mem_we}, 32'h0);
      rst_n = 1'b1;

      while (sb.size() > 0 && cyc < WATCHDOG) @(negedge clk);
      check(cyc < WATCHDOG, "R2", "watchdog", 32'(cyc), 32'(WATCHDOG));
      check(onehot_bad == 0, "R2", "one-hot violations", 32'(onehot_bad), 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule